// File: doc/BRIEF.md
# Interrupt In-Service Priority Tracker

This block records which interrupt priority levels a microcontroller core is servicing. There are three levels. Power-fail is the highest and cannot be masked. High priority comes next, and low priority is the lowest. An acknowledge strobe carries a level code and marks the moment the core vectors to a handler. The tracker then raises that level's in-service flag. A return-from-interrupt strobe lowers the flag of the most recently entered level that is still active. The flags are read-only status bits. A separate current-level code lets a neighbouring arbiter hold back requests of the same or lower priority.

A handler can only be interrupted by a handler of higher priority. Because of this, the set of raised flags is enough to describe the whole nesting stack. The tracker is a state machine whose eight states are exactly the eight flag combinations:

- `ST_IDLE`: nothing in service.
- `ST_L`, `ST_H`, `ST_P`: a single level in service.
- `ST_HL`: high nested over low.
- `ST_PL`: power-fail nested over low.
- `ST_PH`: power-fail nested over high.
- `ST_PHL`: all three levels.

Each state has three kinds of transition:

- An accepted acknowledge moves to the state with one more, higher, bit set. The possible moves are IDLE→L/H/P, L→HL/PL, H→PH and HL→PHL.
- A return moves to the state with its top bit removed. The possible moves are L/H/P→IDLE, HL/PL→L, PH→H and PHL→HL.
- In every other case the state holds.

The parameter `HAS_PF` set to 0 builds the tracker without the power-fail level.

Top module: `iss_tracker`

## Requirements
- R1: After reset all three flags are 0 and `cur_lvl_o` is 0.
- R2: Level codes on `ack_lvl_i` are 0 for low, 1 for high and 2 for power-fail. An acknowledge whose level is strictly above the highest flag set raises that level's flag one cycle later.
- R3: An acknowledge whose level is equal to or below the highest flag set leaves all flags unchanged.
- R4: A return clears only the highest flag that is set. Lower nested flags stay set.
- R5: A return when no flag is set leaves all flags unchanged.
- R6: When an acknowledge and a return occur in the same cycle, the return is applied first. The acknowledge is then judged against the flags that remain.
- R7: `cur_lvl_o` reports the highest flag set: 3 for power-fail, 2 for high, 1 for low, 0 for none.
- R8: An acknowledge with level code 3 is ignored.
- R9: With `HAS_PF` = 0, a power-fail acknowledge is ignored and `flag_pf_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_i | input | 1 | Core vectors to a handler this cycle |
| ack_lvl_i | input | 2 | Level of the acknowledged interrupt |
| reti_i | input | 1 | Core executes return-from-interrupt this cycle |
| flag_pf_o | output | 1 | Power-fail in service |
| flag_hi_o | output | 1 | High priority in service |
| flag_lo_o | output | 1 | Low priority in service |
| cur_lvl_o | output | 2 | Highest level in service (0 = none) |

## Verification
The acknowledge and the return can land in the same cycle. That is where an ordering mistake would show. The random stimulus asserts both strobes together in a large share of cycles, from every nesting state. Directed cases add more: a return from high paired with a high acknowledge (re-entry is accepted), and a return from low paired with a low acknowledge. Each outcome is judged against a bench model that applies the return before the acknowledge. It is compared with the flags and the current level on the next cycle.

// File: rtl/iss_pkg.sv
package iss_pkg;
    localparam int LVL_W  = 2;
    localparam int NLEVEL = 3;

    localparam logic [LVL_W-1:0] CODE_LO  = 2'd0;
    localparam logic [LVL_W-1:0] CODE_HI  = 2'd1;
    localparam logic [LVL_W-1:0] CODE_PF  = 2'd2;

    // State value equals the flag vector {pf, hi, lo}
    typedef enum logic [NLEVEL-1:0] {
        ST_IDLE = 3'b000,
        ST_L    = 3'b001,
        ST_H    = 3'b010,
        ST_HL   = 3'b011,
        ST_P    = 3'b100,
        ST_PL   = 3'b101,
        ST_PH   = 3'b110,
        ST_PHL  = 3'b111
    } nest_t;
endpackage

// File: rtl/iss_ack_decode.sv
module iss_ack_decode
    import iss_pkg::*;
#(
    parameter bit HAS_PF = 1'b1
) (
    input  logic             ack_i,
    input  logic [LVL_W-1:0] ack_lvl_i,
    output logic [NLEVEL-1:0] req_o     // one-hot {pf, hi, lo}
);
    always_comb begin
        req_o = '0;
        if (ack_i) begin
            unique case (ack_lvl_i)
                CODE_LO: req_o[0] = 1'b1;
                CODE_HI: req_o[1] = 1'b1;
                CODE_PF: req_o[2] = HAS_PF;
                default: req_o    = '0;
            endcase
        end
    end
endmodule

// File: rtl/iss_nest_fsm.sv
module iss_nest_fsm
    import iss_pkg::*;
#(
    parameter bit HAS_PF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLEVEL-1:0] req_i,
    input  logic              ret_i,
    output logic [NLEVEL-1:0] flags_o
);
    nest_t state_q, after_ret, state_d;

    // Return is applied first
    always_comb begin
        after_ret = state_q;
        if (ret_i) begin
            unique case (state_q)
                ST_IDLE: after_ret = ST_IDLE;
                ST_L:    after_ret = ST_IDLE;
                ST_H:    after_ret = ST_IDLE;
                ST_P:    after_ret = ST_IDLE;
                ST_HL:   after_ret = ST_L;
                ST_PL:   after_ret = ST_L;
                ST_PH:   after_ret = ST_H;
                ST_PHL:  after_ret = ST_HL;
            endcase
        end
    end

    // Then the acknowledge, judged against the remaining stack
    always_comb begin
        state_d = after_ret;
        unique case (after_ret)
            ST_IDLE: begin
                if (req_i[2])      state_d = ST_P;
                else if (req_i[1]) state_d = ST_H;
                else if (req_i[0]) state_d = ST_L;
            end
            ST_L: begin
                if (req_i[2])      state_d = ST_PL;
                else if (req_i[1]) state_d = ST_HL;
            end
            ST_H: begin
                if (req_i[2])      state_d = ST_PH;
            end
            ST_HL: begin
                if (req_i[2])      state_d = ST_PHL;
            end
            ST_P, ST_PL, ST_PH, ST_PHL: state_d = after_ret;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: flags_o = 3'b000;
            ST_L:    flags_o = 3'b001;
            ST_H:    flags_o = 3'b010;
            ST_HL:   flags_o = 3'b011;
            ST_P:    flags_o = 3'b100;
            ST_PL:   flags_o = 3'b101;
            ST_PH:   flags_o = 3'b110;
            ST_PHL:  flags_o = 3'b111;
        endcase
    end

    a_r5_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && req_i == '0 && flags_o == '0) |=> flags_o == '0);
    a_r4_top_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && req_i == '0 && flags_o[2]) |=> (!flags_o[2] && flags_o[1:0] == $past(flags_o[1:0])));
    a_r3_no_lower_nest: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_i && flags_o[2]) |=> flags_o == $past(flags_o));
    a_r2_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_i && flags_o == '0 && req_i[1]) |=> flags_o == 3'b010);
    a_r6_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && flags_o == 3'b010 && req_i[1]) |=> flags_o == 3'b010);
    a_r9_no_pf_state: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_PF |-> !flags_o[2]);
endmodule

// File: rtl/iss_level_encode.sv
module iss_level_encode
    import iss_pkg::*;
(
    input  logic [NLEVEL-1:0] flags_i,
    output logic [LVL_W-1:0]  cur_lvl_o
);
    always_comb begin
        unique casez (flags_i)
            3'b1??:  cur_lvl_o = 2'd3;
            3'b01?:  cur_lvl_o = 2'd2;
            3'b001:  cur_lvl_o = 2'd1;
            default: cur_lvl_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/iss_tracker.sv
module iss_tracker
    import iss_pkg::*;
#(
    parameter bit HAS_PF = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_i,
    input  logic [1:0] ack_lvl_i,
    input  logic       reti_i,
    output logic       flag_pf_o,
    output logic       flag_hi_o,
    output logic       flag_lo_o,
    output logic [1:0] cur_lvl_o
);
    logic [NLEVEL-1:0] req;
    logic [NLEVEL-1:0] flags;

    iss_ack_decode #(.HAS_PF(HAS_PF)) u_dec (
        .ack_i     (ack_i),
        .ack_lvl_i (ack_lvl_i),
        .req_o     (req)
    );

    iss_nest_fsm #(.HAS_PF(HAS_PF)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .ret_i   (reti_i),
        .flags_o (flags)
    );

    iss_level_encode u_enc (
        .flags_i   (flags),
        .cur_lvl_o (cur_lvl_o)
    );

    generate
        if (HAS_PF) begin : g_pf
            assign flag_pf_o = flags[2];
        end else begin : g_no_pf
            assign flag_pf_o = 1'b0;
        end
    endgenerate
    assign flag_hi_o = flags[1];
    assign flag_lo_o = flags[0];

    a_r7_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_o == 2'd2 && !reti_i) |=> (flag_hi_o || flag_pf_o));
    a_r8_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_lvl_i == 2'd3 && !reti_i) |=> $stable({flag_pf_o, flag_hi_o, flag_lo_o}));
endmodule

// File: tb/test_iss_tracker.sv
module test_iss_tracker;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack = 1'b0;
    logic [1:0] lvl = 2'd0;
    logic ret = 1'b0;
    logic pf, hi, lo, npf, nhi, nlo;
    logic [1:0] cur, ncur;

    int checks = 0;
    int errors = 0;
    logic [2:0] mf, mn;   // model flags for both builds
    string tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    iss_tracker #(.HAS_PF(1'b1)) i_iss_tracker (
        .clk(clk), .rst_n(rst_n), .ack_i(ack), .ack_lvl_i(lvl), .reti_i(ret),
        .flag_pf_o(pf), .flag_hi_o(hi), .flag_lo_o(lo), .cur_lvl_o(cur));

    iss_tracker #(.HAS_PF(1'b0)) i_iss_tracker_nopf (
        .clk(clk), .rst_n(rst_n), .ack_i(ack), .ack_lvl_i(lvl), .reti_i(ret),
        .flag_pf_o(npf), .flag_hi_o(nhi), .flag_lo_o(nlo), .cur_lvl_o(ncur));

    function automatic logic [2:0] model(input logic [2:0] f, input logic a,
                                         input logic [1:0] c, input logic r, input bit haspf);
        logic [2:0] m;
        int top, idx;
        m = f;
        if (r) begin
            if (m[2]) m[2] = 1'b0;
            else if (m[1]) m[1] = 1'b0;
            else m[0] = 1'b0;
        end
        top = m[2] ? 2 : m[1] ? 1 : m[0] ? 0 : -1;
        idx = (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : (c == 2'd2 && haspf) ? 2 : -1;
        if (a && idx >= 0 && idx > top) m[idx] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] lvl_of(input logic [2:0] f);
        return f[2] ? 2'd3 : f[1] ? 2'd2 : f[0] ? 2'd1 : 2'd0;
    endfunction

    task automatic check(input string t);
        checks++;
        if ({pf, hi, lo} !== mf) begin
            errors++;
            $display("FAIL %s flags actual %b expected %b", t, {pf, hi, lo}, mf);
        end
        checks++;
        if (cur !== lvl_of(mf)) begin
            errors++;
            $display("FAIL R7 cur_lvl actual %0d expected %0d", cur, lvl_of(mf));
        end
        checks++;
        if ({npf, nhi, nlo} !== mn || npf !== 1'b0) begin
            errors++;
            $display("FAIL R9 nopf flags actual %b expected %b", {npf, nhi, nlo}, mn);
        end
    endtask

    // Drive one cycle, then check at the following falling edge
    task automatic step(input logic a, input logic [1:0] c, input logic r);
        if (r && a) tag = "R6";
        else if (r && mf == 3'b000) tag = "R5";
        else if (r) tag = "R4";
        else if (a && c == 2'd3) tag = "R8";
        else if (a && model(mf, a, c, 1'b0, 1'b1) != mf) tag = "R2";
        else if (a) tag = "R3";
        else tag = "R7";
        ack = a; lvl = c; ret = r;
        mf = model(mf, a, c, r, 1'b1);
        mn = model(mn, a, c, r, 1'b0);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        mf = 3'b000; mn = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1");                    // reset state
        step(1'b0, 2'd0, 1'b1);         // R5 return with nothing set
        step(1'b1, 2'd0, 1'b0);         // R2 low
        step(1'b1, 2'd0, 1'b0);         // R3 same level
        step(1'b1, 2'd3, 1'b0);         // R8 reserved
        step(1'b1, 2'd1, 1'b0);         // R2 high over low
        step(1'b1, 2'd2, 1'b0);         // R2 pf over high (R9 for nopf)
        step(1'b1, 2'd0, 1'b0);         // R3 lower ignored
        step(1'b0, 2'd0, 1'b1);         // R4 clears pf only
        step(1'b1, 2'd1, 1'b1);         // R6 return high then re-enter high
        step(1'b0, 2'd0, 1'b1);         // R4
        step(1'b1, 2'd0, 1'b1);         // R6 return low then low accepted
        step(1'b0, 2'd0, 1'b1);         // R4
        for (int i = 0; i < 3000; i++) begin
            logic a, r;
            logic [1:0] c;
            a = ($urandom % 100) < 55;
            r = ($urandom % 100) < 40;
            c = 2'($urandom % 4);
            step(a, c, r);
        end
        rst_n = 1'b0;
        ack = 1'b0; ret = 1'b0;
        mf = 3'b000; mn = 3'b000;
        @(negedge clk);
        check("R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule